// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit sits beside a small in-order CPU and decides which interrupt, if any, the CPU services next. It watches a set of level-sensitive request lines. Every line except line 0 has its own enable bit, which comes from a control register held outside the unit. All of those lines are also gated by one global enable flag that the unit owns. Line 0 is the reset vector. It ignores every mask.

The CPU pulses an accept strobe at each instruction boundary. In that cycle the unit picks the qualified request with the lowest index. One cycle later it raises an acknowledge for exactly one cycle, together with the winning index and its vector address. Taking an interrupt clears the global flag in hardware. A return-from-interrupt strobe sets the flag again. Software can also set or clear the flag directly through write strobes. The unit saves no status and no return address. The CPU and its software handle those.

Top module: `irq_vector_unit`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it falls, ack_o is 0 and gie_o is 0.
- R2: When several qualified requests are present at an accept, the one with the smallest index is taken.
- R3: While gie_o is 0, a request on any line 1..N-1 is not taken, whatever its enable bit.
- R4: A request on line i (i >= 1) whose enable bit en_i[i] is 0 is not taken, even with gie_o at 1. A higher-index enabled request is taken in its place.
- R5: Line 0 is taken whenever it is high at an accept, regardless of gie_o.
- R6: vec_addr_o equals VEC_BASE + 2 × ack_idx_o. Both are valid in the cycle ack_o is 1.
- R7: ack_o rises only in the cycle after an accept_i cycle with a qualified request, and stays high for exactly that one cycle per take. Without accept_i, neither ack_o nor gie_o is affected by requests.
- R8: In the cycle after a take, gie_o is 0.
- R9: A cycle with reti_i at 1 and no take leaves gie_o at 1 in the following cycle.
- R10: In a cycle with no take, a gie_set_i strobe sets gie_o and a gie_clr_i strobe clears it. When both strobes arrive together, the set wins. A take in the same cycle overrides any set.
- R11: A request that drops before the accept cycle is not remembered and produces no acknowledge.
- R12: pending_o is high in the same cycle, combinationally, exactly when at least one request is qualified under the current gie_o and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Level request lines; bit 0 is the unmaskable reset vector |
| en_i | input | NUM_SRC-1 | Individual enables for lines 1..NUM_SRC-1 (bit i enables line i) |
| accept_i | input | 1 | CPU instruction-boundary strobe; a take may happen only here |
| gie_set_i | input | 1 | Software strobe that sets the global enable |
| gie_clr_i | input | 1 | Software strobe that clears the global enable |
| reti_i | input | 1 | Return-from-interrupt strobe; sets the global enable |
| ack_o | output | 1 | One-cycle acknowledge of a taken interrupt |
| ack_idx_o | output | $clog2(NUM_SRC) | Index of the taken request |
| vec_addr_o | output | ADDR_W | Vector address of the taken request |
| gie_o | output | 1 | Current global interrupt enable |
| pending_o | output | 1 | A qualified request exists this cycle |

## Verification
The assertions assume that the inputs are stable single-cycle values sampled at the rising edge. They assume nothing about how often accept_i or the software strobes arrive, so back-to-back takes, a simultaneous set and clear, and a return coinciding with a take are all legal. The stimulus changes every input only at the falling edge. Directed cycles place a return, a software set and a take in the same cycle. A long pseudo-random phase mixes sparse request patterns, random enables and independent strobe rates against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        GIE_KEEP  = 2'd0,
        GIE_RAISE = 2'd1,
        GIE_DROP  = 2'd2
    } gie_op_e;

    // Hardware clear beats everything; any set beats a software clear.
    function automatic gie_op_e gie_next_op(input logic hw_clr,
                                            input logic sw_set,
                                            input logic sw_clr,
                                            input logic reti);
        if (hw_clr)
            return GIE_DROP;
        else if (sw_set || reti)
            return GIE_RAISE;
        else if (sw_clr)
            return GIE_DROP;
        else
            return GIE_KEEP;
    endfunction

    // Vectors are two address units apart.
    function automatic int unsigned vec_offset(input int unsigned idx);
        return idx << 1;
    endfunction

endpackage

// File: rtl/irq_masker.sv
module irq_masker #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:1] en_i,
    input  logic               gie_i,
    output logic [NUM_SRC-1:0] qual_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        if (i == 0) begin : g_reset_line
            assign qual_o[i] = req_i[i];
        end else begin : g_masked_line
            assign qual_o[i] = req_i[i] & en_i[i] & gie_i;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] qual_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (qual_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hw_clr_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic reti_i,
    output logic gie_o
);
    gie_op_e op;
    logic    gie_q;

    assign op = gie_next_op(hw_clr_i, sw_set_i, sw_clr_i, reti_i);

    always_ff @(posedge clk) begin
        if (rst)
            gie_q <= 1'b0;
        else begin
            case (op)
                GIE_RAISE: gie_q <= 1'b1;
                GIE_DROP:  gie_q <= 1'b0;
                default:   gie_q <= gie_q;
            endcase
        end
    end

    assign gie_o = gie_q;

    AST_HW_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        hw_clr_i |=> !gie_q); // R10
    AST_RETI_SETS: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !hw_clr_i) |=> gie_q); // R9
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned VEC_BASE = 0,
    localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:1] en_i,
    input  logic               accept_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               reti_i,
    output logic               ack_o,
    output logic [IDX_W-1:0]   ack_idx_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               gie_o,
    output logic               pending_o
);
    logic [NUM_SRC-1:0] qual;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               take;
    logic               gie;
    logic               ack_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  vec_q;
    logic [NUM_SRC-1:0] below_mask;

    irq_masker #(.NUM_SRC(NUM_SRC)) u_mask (
        .req_i  (req_i),
        .en_i   (en_i),
        .gie_i  (gie),
        .qual_o (qual)
    );

    irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .qual_i  (qual),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    assign take = accept_i & win_valid;

    irq_gie_ctrl u_gie (
        .clk      (clk),
        .rst      (rst),
        .hw_clr_i (take),
        .sw_set_i (gie_set_i),
        .sw_clr_i (gie_clr_i),
        .reti_i   (reti_i),
        .gie_o    (gie)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            idx_q <= '0;
            vec_q <= ADDR_W'(VEC_BASE);
        end else begin
            ack_q <= take;
            if (take) begin
                idx_q <= win_idx;
                vec_q <= ADDR_W'(VEC_BASE + vec_offset(32'(win_idx)));
            end
        end
    end

    assign ack_o      = ack_q;
    assign ack_idx_o  = idx_q;
    assign vec_addr_o = vec_q;
    assign gie_o      = gie;
    assign pending_o  = win_valid;

    assign below_mask = (NUM_SRC'(1) << win_idx) - NUM_SRC'(1);

    AST_NO_SPONT_ACK: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> !ack_o); // R7
    AST_GIE_GATES: assert property (@(posedge clk) disable iff (rst)
        (accept_i && !gie && !req_i[0]) |=> !ack_o); // R3
    AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !gie_o); // R8
    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (req_i[win_idx] && (qual & below_mask) == '0)); // R2
    AST_RESET_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (accept_i && req_i[0]) |=> (ack_o && ack_idx_o == '0)); // R5
endmodule

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
    localparam int N     = 16;
    localparam int AW    = 16;
    localparam int BASE  = 0;
    localparam int IW    = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req;
    logic [N-1:1]  en;
    logic          acc, sset, sclr, reti;
    logic          ack, gie, pend;
    logic [IW-1:0] idx;
    logic [AW-1:0] vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    bit    have_model = 0;
    bit    m_ack, m_gie;
    int    m_idx, m_vec;
    string prev_tag = "R1";

    always #2 clk = ~clk;

    irq_vector_unit #(.NUM_SRC(N), .ADDR_W(AW), .VEC_BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .en_i(en), .accept_i(acc),
        .gie_set_i(sset), .gie_clr_i(sclr), .reti_i(reti),
        .ack_o(ack), .ack_idx_o(idx), .vec_addr_o(vec),
        .gie_o(gie), .pending_o(pend)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] q);
        for (int i = 0; i < N; i++) if (q[i]) return i;
        return -1;
    endfunction

    task automatic check_outputs();
        if (!have_model) return;
        cmp(prev_tag, "ack", int'(ack), int'(m_ack));
        cmp(prev_tag, "gie", int'(gie), int'(m_gie));
        if (m_ack) begin
            cmp(prev_tag, "index", int'(idx), m_idx);
            cmp(prev_tag, "vector R6", int'(vec), m_vec);
        end
    endtask

    task automatic step(input logic r, input logic [N-1:0] rq, input logic [N-1:1] e,
                        input logic a, input logic s, input logic c, input logic t,
                        input string tag);
        logic [N-1:0] q;
        int w;
        bit tk;
        bit n_ack, n_gie;
        int n_idx, n_vec;
        @(negedge clk);
        check_outputs();
        rst = r; req = rq; en = e; acc = a; sset = s; sclr = c; reti = t;
        #1;
        q = '0;
        q[0] = rq[0];
        for (int i = 1; i < N; i++) q[i] = rq[i] & e[i] & m_gie;
        w = lowest(q);
        if (have_model) cmp({tag, " R12"}, "pending", int'(pend), int'(w >= 0));
        tk = a && (w >= 0);
        if (r) begin
            n_ack = 0; n_gie = 0; n_idx = m_idx; n_vec = m_vec;
        end else begin
            n_ack = tk;
            n_idx = tk ? w : m_idx;
            n_vec = tk ? BASE + 2 * w : m_vec;
            if (tk)             n_gie = 0;
            else if (s || t)    n_gie = 1;
            else if (c)         n_gie = 0;
            else                n_gie = m_gie;
        end
        @(posedge clk);
        m_ack = n_ack; m_gie = n_gie; m_idx = n_idx; m_vec = n_vec;
        have_model = 1;
        prev_tag = tag;
    endtask

    localparam logic [N-1:1] ALL_EN = '1;

    initial begin
        rst = 1; req = '0; en = '0; acc = 0; sset = 0; sclr = 0; reti = 0;
        // R1: reset behaviour
        repeat (3) step(1, 16'hFFFF, ALL_EN, 1, 1, 0, 1, "R1");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R1");
        // R3: global enable low blocks lines 1..N-1
        step(0, 16'hFFFE, ALL_EN, 1, 0, 0, 0, "R3");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R3");
        // R5: line 0 ignores masks
        step(0, 16'h0001, '0, 1, 0, 0, 0, "R5");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R5");
        // R10: software strobes
        step(0, '0, ALL_EN, 0, 1, 0, 0, "R10");
        step(0, '0, ALL_EN, 0, 0, 1, 0, "R10");
        step(0, '0, ALL_EN, 0, 1, 1, 0, "R10");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R10");
        // R2 and R8: lowest index wins, gie dropped after take
        step(0, 16'h0228, ALL_EN, 1, 0, 0, 0, "R2");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R8");
        // R9: return sets global enable
        step(0, '0, ALL_EN, 0, 0, 0, 1, "R9");
        // R4: disabled line 3 skipped in favour of 9
        step(0, 16'h0208, ALL_EN & ~15'(1 << 2), 1, 0, 0, 0, "R4");
        step(0, '0, ALL_EN, 0, 0, 0, 1, "R9");
        // R11: request withdrawn before accept
        step(0, 16'h0040, ALL_EN, 0, 0, 0, 0, "R11");
        step(0, '0, ALL_EN, 1, 0, 0, 0, "R11");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R11");
        // R10: take beats simultaneous set and return
        step(0, 16'h0004, ALL_EN, 1, 1, 0, 1, "R10");
        step(0, '0, ALL_EN, 0, 0, 0, 1, "R10");
        // R7: request without accept
        step(0, 16'h0100, ALL_EN, 0, 0, 0, 0, "R7");
        step(0, 16'h0100, ALL_EN, 0, 0, 0, 0, "R7");
        // R6: highest vector
        step(0, 16'h8000, ALL_EN, 1, 0, 0, 0, "R6");
        step(0, '0, ALL_EN, 0, 0, 0, 1, "R6");
        // back-to-back: line 0 while gie dropped
        step(0, 16'h0011, ALL_EN, 1, 0, 0, 0, "R5");
        step(0, 16'h0011, ALL_EN, 1, 0, 0, 0, "R5");
        step(0, '0, ALL_EN, 0, 0, 0, 0, "R5");
        // random mix against the model
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] rq;
            rq = N'($urandom) & N'($urandom) & N'($urandom);
            if ($urandom_range(0, 7) != 0) rq[0] = 1'b0;
            step(0, rq, (N-1)'($urandom), ($urandom_range(0, 1) == 1),
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 19) == 0),
                 ($urandom_range(0, 9) == 0), "R2");
        end
        @(negedge clk);
        check_outputs();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule